// File: doc/BRIEF.md
# Fine-grained register read trap unit

The unit holds a 64-bit hypervisor control word whose bits are active-low trap enables. Each implemented bit guards reads of one group of debug, trace or monitor registers. For every read of a guarded register, the unit takes the privilege level, the state of the hypervisor level and the host-mode bits. From these it decides whether the read must be diverted to privilege level 2.

The same unit also decides what happens when software accesses the control word itself. That access can be undefined, can trap to level 2 or level 3, can be redirected to a memory shadow at a fixed offset, or can read or write the word directly. Every request is a single-cycle strobe. The verdict appears on the registered outputs one clock later. Taking the exception and performing the memory access belong to the surrounding core.

Top module: `fgt_read_trap`

## Requirements
- R1: After the synchronous active-low reset, the control word is all zeros, so every implemented trap is armed. All response outputs are zero.
- R2: A target read (op code 0) at level 1 of index k traps to level 2 when bit k is implemented and holds 0. The response then carries syndrome 0x18. When bit k holds 1, no trap is raised. Outcomes appear on the cycle after the request strobe, together with `rsp_valid`.
- R3: A target read traps only when level 2 is both present and enabled in the current security state.
- R4: At level 0, only bits 2, 3, 8, 9, 10, 11, 13 and 14 can trap. They do not trap when host E2H and TGE are both 1. The host bits have no effect on level-1 target reads.
- R5: Target reads at levels 2 and 3 never trap. An index whose bit is reserved never traps.
- R6: While `hp_pending` is high, a request produces no trap, undefined or redirect outcome. A write requested under `hp_pending` leaves the control word unchanged.
- R7: Implemented bits are 0 to 20, 22 and 23. All other bits read as zero and ignore writes.
- R8: A read (op 1) or write (op 2) of the control word at level 0 is undefined.
- R9: At level 1, an access to the control word is decided by `nv_bits`.
  - If bits 2 and 0 are both set, the access is redirected, with `redirect_ofs` = 0x1A0.
  - Otherwise, if bit 0 is set, it traps to level 2 with syndrome 0x18.
  - Otherwise it is undefined.
  - None of these outcomes changes the word.
- R10: At level 2, an access to the control word depends on level 3.
  - When level 3 is present and its fine-grained enable is 0, the access is undefined if `sdd_undef_prio` or `sdd_undef` is set. Otherwise it traps to level 3 with syndrome 0x18.
  - Otherwise the access is direct.
- R11: At level 3, an access to the control word is always direct. With level 2 absent, direct reads return zero and direct writes are ignored.
- R12: At most one of trap-to-2, trap-to-3, undefined and redirect is high. The syndrome is zero whenever no trap is raised. The offset is zero whenever there is no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 target read, 1 control read, 2 control write, 3 no action |
| req_lvl | input | 2 | Current privilege level |
| req_idx | input | 6 | Control bit guarding the target register |
| req_wdata | input | 64 | Write data for op 2 |
| el2_present | input | 1 | Level 2 is implemented |
| el2_enabled | input | 1 | Level 2 is enabled in the current security state |
| el3_present | input | 1 | Level 3 is implemented |
| host_e2h | input | 1 | Effective host E2H bit |
| host_tge | input | 1 | Effective host TGE bit |
| nv_bits | input | 3 | Nested-virtualization bits, [2] shadow, [0] base |
| el3_fgt_en | input | 1 | Level-3 fine-grained enable |
| sdd_undef_prio | input | 1 | Undefined-priority condition |
| sdd_undef | input | 1 | Undefined condition for level-3 gating |
| hp_pending | input | 1 | Higher-priority exception pending |
| rsp_valid | output | 1 | Response valid |
| trap_el2 | output | 1 | Trap to level 2 |
| trap_el3 | output | 1 | Trap to level 3 |
| undef | output | 1 | Undefined instruction |
| redirect | output | 1 | Redirect to memory shadow |
| redirect_ofs | output | 12 | Shadow offset |
| syndrome | output | 6 | Syndrome class |
| rdata | output | 64 | Direct read data |

## Verification
The hardest case to reach is a level-0 target read of a bit that can trap at level 0, with the word bit clear, while host E2H and TGE are both set. Reaching it needs a specific word value, the right index and the right host pair all together. The bench gets there with a full sweep: four written word patterns, all 64 indexes, all four levels, all four host-bit pairs and all four level-2 states. The control-word path gets the same treatment, sweeping every nested-virtualization code against every level-3 gating input. Each write is followed by a direct read-back, which shows whether the word changed.

// File: rtl/fgt_pkg.sv
// Shared codes and constants for the fine-grained read trap unit.
// Assumes privilege levels are encoded 0..3 and op codes fit two bits.
package fgt_pkg;
    typedef enum logic [1:0] {
        OP_TGT_RD = 2'd0,
        OP_CTL_RD = 2'd1,
        OP_CTL_WR = 2'd2,
        OP_NONE   = 2'd3
    } op_e;

    localparam logic [1:0] LVL_USR = 2'd0;
    localparam logic [1:0] LVL_OS  = 2'd1;
    localparam logic [1:0] LVL_HYP = 2'd2;
    localparam logic [1:0] LVL_MON = 2'd3;

    localparam int         SYN_W      = 6;
    localparam logic [5:0] SYN_FGT    = 6'h18;
    localparam int         OFS_W      = 12;
    localparam logic [11:0] SHADOW_OFS = 12'h1A0;

    // Verdict for an access to the control word itself.
    typedef struct packed {
        logic trap2;
        logic trap3;
        logic undef;
        logic redir;
        logic direct;
    } verdict_t;
endpackage

// File: rtl/fgt_ctl_store.sv
// Control word storage. Only positions set in IMPL_MASK hold state;
// every other position stays zero whatever is written.
// Assumes the write enable is already qualified by the access gating.
module fgt_ctl_store #(
    parameter int                CTRL_W    = 64,
    parameter logic [CTRL_W-1:0] IMPL_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] q
);
    // Holds the word; reset arms every trap, writes drop reserved bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= wr_data & IMPL_MASK;
    end
endmodule

// File: rtl/fgt_tgt_trap.sv
// Per-read trap decision for guarded target registers.
// A clear implemented bit arms the trap. Level 1 traps for every
// implemented bit; level 0 only for bits in LVL0_MASK and only outside
// host mode. Assumes el2_active already combines presence and enable.
module fgt_tgt_trap
    import fgt_pkg::*;
#(
    parameter int                CTRL_W    = 64,
    parameter logic [CTRL_W-1:0] IMPL_MASK = '1,
    parameter logic [CTRL_W-1:0] LVL0_MASK = '0,
    localparam int               IDX_W     = $clog2(CTRL_W)
) (
    input  logic [CTRL_W-1:0] ctl,
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        lvl,
    input  logic              el2_active,
    input  logic              host_mode,
    output logic              trap
);
    logic armed;

    // Selects the guarding bit and applies the level and host rules.
    always_comb begin
        armed = IMPL_MASK[idx] & ~ctl[idx];
        case (lvl)
            LVL_OS:  trap = armed;
            LVL_USR: trap = armed & LVL0_MASK[idx] & ~host_mode;
            default: trap = 1'b0;
        endcase
        trap = trap & el2_active;
    end
endmodule

// File: rtl/fgt_self_gate.sv
// Gating for reads and writes of the control word itself.
// Level 0 is undefined. Level 1 follows the nested-virtualization bits.
// Level 2 follows the level-3 fine-grained enable. Level 3 is direct.
// Assumes nv_bits[2] selects the memory shadow and nv_bits[0] the trap.
module fgt_self_gate
    import fgt_pkg::*;
(
    input  logic [1:0] lvl,
    input  logic [2:0] nv_bits,
    input  logic       el3_present,
    input  logic       el3_fgt_en,
    input  logic       sdd_undef_prio,
    input  logic       sdd_undef,
    output verdict_t   verdict
);
    // Walks the layered level rules in priority order.
    always_comb begin
        verdict = '0;
        case (lvl)
            LVL_USR: verdict.undef = 1'b1;
            LVL_OS: begin
                if (nv_bits[2] && nv_bits[0])
                    verdict.redir = 1'b1;
                else if (nv_bits[0])
                    verdict.trap2 = 1'b1;
                else
                    verdict.undef = 1'b1;
            end
            LVL_HYP: begin
                if (el3_present && !el3_fgt_en) begin
                    if (sdd_undef_prio || sdd_undef)
                        verdict.undef = 1'b1;
                    else
                        verdict.trap3 = 1'b1;
                end else begin
                    verdict.direct = 1'b1;
                end
            end
            default: verdict.direct = 1'b1;
        endcase
    end
endmodule

// File: rtl/fgt_read_trap.sv
// Top of the fine-grained read trap unit.
// Accepts one request per strobe. Returns a registered verdict one
// cycle later. Assumes the core holds off exception entry and performs
// any redirected memory access itself.
module fgt_read_trap
    import fgt_pkg::*;
#(
    parameter int                CTRL_W    = 64,
    parameter logic [CTRL_W-1:0] IMPL_MASK = 64'h0000_0000_00DF_FFFF,
    parameter logic [CTRL_W-1:0] LVL0_MASK = 64'h0000_0000_0000_6F0C,
    localparam int               IDX_W     = $clog2(CTRL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [1:0]        req_lvl,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [CTRL_W-1:0] req_wdata,
    input  logic              el2_present,
    input  logic              el2_enabled,
    input  logic              el3_present,
    input  logic              host_e2h,
    input  logic              host_tge,
    input  logic [2:0]        nv_bits,
    input  logic              el3_fgt_en,
    input  logic              sdd_undef_prio,
    input  logic              sdd_undef,
    input  logic              hp_pending,
    output logic              rsp_valid,
    output logic              trap_el2,
    output logic              trap_el3,
    output logic              undef,
    output logic              redirect,
    output logic [OFS_W-1:0]  redirect_ofs,
    output logic [SYN_W-1:0]  syndrome,
    output logic [CTRL_W-1:0] rdata
);
    logic [CTRL_W-1:0] ctl_q;
    logic              tgt_trap;
    verdict_t          self_v;
    logic              t2_d, t3_d, ud_d, rd_d, dir_d;
    logic              wr_en;
    logic [CTRL_W-1:0] rdata_d;

    fgt_ctl_store #(.CTRL_W(CTRL_W), .IMPL_MASK(IMPL_MASK)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (req_wdata),
        .q       (ctl_q)
    );

    fgt_tgt_trap #(.CTRL_W(CTRL_W), .IMPL_MASK(IMPL_MASK), .LVL0_MASK(LVL0_MASK)) u_tgt (
        .ctl        (ctl_q),
        .idx        (req_idx),
        .lvl        (req_lvl),
        .el2_active (el2_present & el2_enabled),
        .host_mode  (host_e2h & host_tge),
        .trap       (tgt_trap)
    );

    fgt_self_gate u_self (
        .lvl            (req_lvl),
        .nv_bits        (nv_bits),
        .el3_present    (el3_present),
        .el3_fgt_en     (el3_fgt_en),
        .sdd_undef_prio (sdd_undef_prio),
        .sdd_undef      (sdd_undef),
        .verdict        (self_v)
    );

    // Chooses the verdict for the request type; a pending higher-priority exception wins.
    always_comb begin
        t2_d  = 1'b0;
        t3_d  = 1'b0;
        ud_d  = 1'b0;
        rd_d  = 1'b0;
        dir_d = 1'b0;
        if (req_valid && !hp_pending) begin
            case (op_e'(req_op))
                OP_TGT_RD: t2_d = tgt_trap;
                OP_CTL_RD, OP_CTL_WR: begin
                    t2_d  = self_v.trap2;
                    t3_d  = self_v.trap3;
                    ud_d  = self_v.undef;
                    rd_d  = self_v.redir;
                    dir_d = self_v.direct;
                end
                default: ;
            endcase
        end
    end

    // Direct accesses reach the word only when level 2 exists.
    always_comb begin
        wr_en   = dir_d && (op_e'(req_op) == OP_CTL_WR) && el2_present;
        rdata_d = (dir_d && (op_e'(req_op) == OP_CTL_RD) && el2_present) ? ctl_q : '0;
    end

    // Registers the response one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            trap_el2     <= 1'b0;
            trap_el3     <= 1'b0;
            undef        <= 1'b0;
            redirect     <= 1'b0;
            redirect_ofs <= '0;
            syndrome     <= '0;
            rdata        <= '0;
        end else begin
            rsp_valid    <= req_valid;
            trap_el2     <= t2_d;
            trap_el3     <= t3_d;
            undef        <= ud_d;
            redirect     <= rd_d;
            redirect_ofs <= rd_d ? SHADOW_OFS : '0;
            syndrome     <= (t2_d || t3_d) ? SYN_FGT : '0;
            rdata        <= rdata_d;
        end
    end
endmodule

// File: rtl/fgt_read_trap_chk.sv
// Property checker for the fine-grained read trap unit, bound to the top.
// Assumes the request inputs are held low while reset is asserted.
module fgt_read_trap_chk
    import fgt_pkg::*;
#(
    parameter int                CTRL_W    = 64,
    parameter logic [CTRL_W-1:0] IMPL_MASK = '1,
    localparam int               IDX_W     = $clog2(CTRL_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [1:0]        req_lvl,
    input logic [IDX_W-1:0]  req_idx,
    input logic              host_e2h,
    input logic              host_tge,
    input logic              hp_pending,
    input logic              rsp_valid,
    input logic              trap_el2,
    input logic              trap_el3,
    input logic              undef,
    input logic              redirect,
    input logic [OFS_W-1:0]  redirect_ofs,
    input logic [SYN_W-1:0]  syndrome,
    input logic [CTRL_W-1:0] rdata
);
    p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({trap_el2, trap_el3, undef, redirect}) <= 1);

    p_syn_on_trap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_el2 || trap_el3) |-> (syndrome == SYN_FGT));

    p_syn_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_el2 || trap_el3) |-> (syndrome == '0));

    p_shadow_ofs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (redirect_ofs == SHADOW_OFS));

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid));

    p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rdata & ~IMPL_MASK) == '0));

    p_usr_self_undef_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && (req_op == 2'd1 || req_op == 2'd2) && req_lvl == LVL_USR && !hp_pending)
        |-> undef);

    p_host_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_op == 2'd0 && req_lvl == LVL_USR && host_e2h && host_tge)
        |-> !trap_el2);

    p_high_lvl_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_op == 2'd0 && req_lvl[1])
        |-> !(trap_el2 || trap_el3 || undef || redirect));

    p_reserved_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_op == 2'd0 && !IMPL_MASK[req_idx]) |-> !trap_el2);

    p_hp_yield_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && hp_pending) |-> !(trap_el2 || trap_el3 || undef || redirect));
endmodule

bind fgt_read_trap fgt_read_trap_chk #(.CTRL_W(CTRL_W), .IMPL_MASK(IMPL_MASK)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_lvl      (req_lvl),
    .req_idx      (req_idx),
    .host_e2h     (host_e2h),
    .host_tge     (host_tge),
    .hp_pending   (hp_pending),
    .rsp_valid    (rsp_valid),
    .trap_el2     (trap_el2),
    .trap_el3     (trap_el3),
    .undef        (undef),
    .redirect     (redirect),
    .redirect_ofs (redirect_ofs),
    .syndrome     (syndrome),
    .rdata        (rdata)
);

// File: tb/fgt_read_trap_test.sv
// Sweep bench for the fine-grained read trap unit.
module fgt_read_trap_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd3;
    logic [1:0]  req_lvl = 2'd0;
    logic [5:0]  req_idx = '0;
    logic [63:0] req_wdata = '0;
    logic        el2_present = 1'b1, el2_enabled = 1'b1, el3_present = 1'b1;
    logic        host_e2h = 1'b0, host_tge = 1'b0;
    logic [2:0]  nv_bits = '0;
    logic        el3_fgt_en = 1'b1, sdd_undef_prio = 1'b0, sdd_undef = 1'b0;
    logic        hp_pending = 1'b0;
    logic        rsp_valid, trap_el2, trap_el3, undef, redirect;
    logic [11:0] redirect_ofs;
    logic [5:0]  syndrome;
    logic [63:0] rdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [63:0] model;

    fgt_read_trap uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_lvl(req_lvl), .req_idx(req_idx), .req_wdata(req_wdata),
        .el2_present(el2_present), .el2_enabled(el2_enabled), .el3_present(el3_present),
        .host_e2h(host_e2h), .host_tge(host_tge), .nv_bits(nv_bits),
        .el3_fgt_en(el3_fgt_en), .sdd_undef_prio(sdd_undef_prio), .sdd_undef(sdd_undef),
        .hp_pending(hp_pending), .rsp_valid(rsp_valid), .trap_el2(trap_el2),
        .trap_el3(trap_el3), .undef(undef), .redirect(redirect),
        .redirect_ofs(redirect_ofs), .syndrome(syndrome), .rdata(rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic bit impl_bit(int i);
        return (i <= 20) || (i == 22) || (i == 23);
    endfunction

    function automatic bit usr_bit(int i);
        return (i == 2) || (i == 3) || (i == 8) || (i == 9) || (i == 10) ||
               (i == 11) || (i == 13) || (i == 14);
    endfunction

    function automatic logic [63:0] impl_word();
        logic [63:0] w = '0;
        for (int i = 0; i < 64; i++) w[i] = impl_bit(i);
        return w;
    endfunction

    // Packs the outcome fields: valid, t2, t3, undef, redirect, ofs, syndrome.
    function automatic logic [63:0] pack(bit v, bit t2, bit t3, bit ud, bit rd);
        return {40'd0, v, t2, t3, ud, rd, (rd ? 12'h1A0 : 12'h0),
                ((t2 || t3) ? 6'h18 : 6'h0)};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives one strobe; returns after the registered response is visible.
    task automatic issue(logic [1:0] op, logic [1:0] lvl, logic [5:0] idx, logic [63:0] wd);
        @(negedge clk);
        req_op = op; req_lvl = lvl; req_idx = idx; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [63:0] outv();
        return {40'd0, rsp_valid, trap_el2, trap_el3, undef, redirect, redirect_ofs, syndrome};
    endfunction

    task automatic direct_write(logic [63:0] wd);
        el3_present = 1'b1; el3_fgt_en = 1'b1; hp_pending = 1'b0;
        issue(2'd2, 2'd3, 6'd0, wd);
        if (el2_present) model = wd & impl_word();
    endtask

    task automatic readback(string req);
        issue(2'd1, 2'd3, 6'd0, '0);
        check(req, rdata, el2_present ? model : 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] pats [4];
        pats[0] = 64'h0; pats[1] = '1;
        pats[2] = 64'h5555_5555_5555_5555; pats[3] = 64'hAAAA_AAAA_AAAA_AAAA;
        model = '0;
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", {outv()[63:0] | rdata}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", outv(), 64'd0);
        readback("R1 word cleared");

        // R2 R3 R4 R5 R7: target sweep under each word pattern.
        for (int p = 0; p < 4; p++) begin
            direct_write(pats[p]);
            readback("R7 reserved bits");
            for (int st = 0; st < 4; st++) begin
                for (int hb = 0; hb < 4; hb++) begin
                    for (int lv = 0; lv < 4; lv++) begin
                        for (int i = 0; i < 64; i++) begin
                            bit live, t;
                            el2_present = st[1]; el2_enabled = st[0];
                            host_e2h = hb[1]; host_tge = hb[0];
                            issue(2'd0, 2'(lv), 6'(i), '0);
                            live = impl_bit(i) && !model[i] && st[1] && st[0];
                            if (lv == 1) t = live;
                            else if (lv == 0) t = live && usr_bit(i) && !(hb == 3);
                            else t = 1'b0;
                            check("R2 R3 R4 R5 target read", outv(), pack(1, t, 0, 0, 0));
                        end
                    end
                end
            end
            el2_present = 1'b1; el2_enabled = 1'b1; host_e2h = 1'b0; host_tge = 1'b0;
        end

        // R8 R9 R10 R11 R12: control word access sweep.
        for (int lv = 0; lv < 4; lv++) begin
            for (int nv = 0; nv < 8; nv++) begin
                for (int g = 0; g < 16; g++) begin
                    for (int op = 1; op <= 2; op++) begin
                        bit t2, t3, ud, rd, dir;
                        logic [63:0] wd;
                        t2 = 0; t3 = 0; ud = 0; rd = 0; dir = 0;
                        if (lv == 0) ud = 1;
                        else if (lv == 1) begin
                            if (nv[2] && nv[0]) rd = 1;
                            else if (nv[0]) t2 = 1;
                            else ud = 1;
                        end else if (lv == 2) begin
                            if (g[3] && !g[2]) begin
                                if (g[1] || g[0]) ud = 1; else t3 = 1;
                            end else dir = 1;
                        end else dir = 1;
                        wd = {4{16'(lv * 4096 + nv * 256 + g * 2 + op)}};
                        el3_present = g[3]; el3_fgt_en = g[2];
                        sdd_undef_prio = g[1]; sdd_undef = g[0];
                        nv_bits = 3'(nv);
                        issue(2'(op), 2'(lv), 6'd0, wd);
                        check("R8 R9 R10 R11 R12 control access", outv(), pack(1, t2, t3, ud, rd));
                        if (op == 1)
                            check("R10 R11 direct read data", rdata, dir ? model : 64'd0);
                        if (op == 2 && dir) model = wd & impl_word();
                        if (op == 2) begin
                            sdd_undef_prio = 0; sdd_undef = 0; nv_bits = 0;
                            readback("R9 R10 word after write");
                        end
                    end
                end
            end
        end

        // R6: higher-priority exception suppresses everything.
        direct_write(64'h0);
        hp_pending = 1'b1;
        issue(2'd0, 2'd1, 6'd0, '0);
        check("R6 target read yields", outv(), pack(1, 0, 0, 0, 0));
        issue(2'd1, 2'd0, 6'd0, '0);
        check("R6 level-0 access yields", outv(), pack(1, 0, 0, 0, 0));
        issue(2'd2, 2'd3, 6'd0, '1);
        check("R6 write yields", outv(), pack(1, 0, 0, 0, 0));
        hp_pending = 1'b0;
        readback("R6 word unchanged");

        // R11: level 2 absent, direct read zero and write ignored.
        direct_write(64'h00F0_0F0F);
        el2_present = 1'b0;
        direct_write('1);
        readback("R11 absent read zero");
        el2_present = 1'b1;
        readback("R11 absent write ignored");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule